// File: doc/BRIEF.md
# Flash Page Dispatch Sequencer

This block takes one host request of several flash pages and spreads it over the targets of a flash array built from several channels, each with several ways. It runs in units of a tick input, normally one per microsecond, and delays are given in ticks. Each page goes to a target and passes through three phases in a fixed order: a select (channel switch) phase, a register transfer phase and a cell phase. The cell phase programs the cells on a write and senses them on a read. Each phase has its own programmable length, and there is one set of lengths for writes and another for reads.

Pages are issued in round-robin order over the targets. The next page is issued as soon as the current page's select phase has had its programmed length, so long cell phases on earlier targets overlap with later issues. A target is never reused before its previous page has left the cell phase. Two targets on one channel never transfer register data at the same time. The done pulse comes only after every page has finished its cell phase, so it marks data stored in the cells and not data sitting in a buffer.

A controller loads the page count, the operation kind and both delay sets, then pulses start. It observes the per-target phase outputs, a strobe for each issued page, the busy flag and the done pulse.

Top module: `flash_page_dispatch`

## Requirements
- R1: Each issued page puts its target through select, then transfer, then cell, with no gap between phases. When no channel wait occurs, the three phases last exactly the programmed select, transfer and cell delays in ticks.
- R2: Page k (counting from 0) of a request goes to target k mod (NCH*NWAY). `issue_stb` pulses for one clock per page, with `issue_tgt` holding that target. Successive issues are one select delay apart when nothing stalls.
- R3: A page whose target is still busy waits until the tick on which that target leaves its cell phase, and it is issued on that same tick. With P = sel+xfer+cell and rho = NCH*NWAY, a request of n >= 1 pages therefore takes sel*(n-1) + max(0, P - rho*sel)*(ceil(n/rho)-1) + P ticks, from the first issue to the last cell exit.
- R4: Target t belongs to channel t mod NCH. At most one target of a channel is in the transfer phase at a time. A target whose select delay has run out while its channel is transferring stays in select, and it enters transfer on the tick the other transfer ends. Among several waiting targets, the lower index goes first.
- R5: A request whose page count is not a multiple of rho finishes with a partial round of fewer pages, and its latency still follows R3.
- R6: `done` pulses for one clock on the tick after the last target leaves its cell phase. `busy` falls on that same edge. The first issue happens on the first tick after start is accepted, so start-to-done is the R3 latency plus 2 ticks.
- R7: `start` is accepted only while `busy` is low. While the block is busy, start is ignored and the page count, issue sequence and latency of the running request stay unchanged.
- R8: `op_rd` = 1 at start selects the read delay set and `op_rd` = 0 selects the write set. The set is captured at start.
- R9: Phase outputs, issue and done advance only on clock edges where `tick_us` is high.
- R10: A page count of 0 issues nothing, and done pulses on the first tick after start.
- R11: After reset, busy, done, issue_stb and all phase outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | Time-base enable, one delay unit per high cycle |
| start | input | 1 | Start request, taken when idle |
| op_rd | input | 1 | 1 = read delay set, 0 = write delay set |
| page_cnt | input | PW | Pages in the request |
| wr_sel_dly | input | DW | Write select delay in ticks |
| wr_xfer_dly | input | DW | Write transfer delay in ticks |
| wr_cell_dly | input | DW | Cell program delay in ticks |
| rd_sel_dly | input | DW | Read select delay in ticks |
| rd_xfer_dly | input | DW | Read transfer delay in ticks |
| rd_cell_dly | input | DW | Cell sense delay in ticks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| issue_stb | output | 1 | One-clock pulse per issued page |
| issue_tgt | output | TW | Target of the issued page |
| sel_o | output | NCH*NWAY | Per-target select phase |
| xfer_o | output | NCH*NWAY | Per-target transfer phase |
| cell_o | output | NCH*NWAY | Per-target cell phase |

## Verification
The properties assume that every delay in the selected set is at least one tick, because a zero delay would wrap the down-counters. They also assume that reset is held for at least one clock before use. The stimulus programs only non-zero delays and keeps the unused delay set at distinct non-zero values, so a wrong set selection shows up as a latency change. The latency formula holds only when no channel wait occurs, so the table vectors keep the transfer delay at or below NCH times the select delay. A single directed case breaks that bound on purpose to exercise channel waiting.

// File: rtl/flash_page_dispatch.sv
`timescale 1ns/1ps
module flash_page_dispatch #(
  parameter int NCH  = 2,
  parameter int NWAY = 2,
  parameter int DW   = 12,
  parameter int PW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_us,
  input  logic                 start,
  input  logic                 op_rd,
  input  logic [PW-1:0]        page_cnt,
  input  logic [DW-1:0]        wr_sel_dly,
  input  logic [DW-1:0]        wr_xfer_dly,
  input  logic [DW-1:0]        wr_cell_dly,
  input  logic [DW-1:0]        rd_sel_dly,
  input  logic [DW-1:0]        rd_xfer_dly,
  input  logic [DW-1:0]        rd_cell_dly,
  output logic                 busy,
  output logic                 done,
  output logic                 issue_stb,
  output logic [$clog2(NCH*NWAY)-1:0] issue_tgt,
  output logic [NCH*NWAY-1:0]  sel_o,
  output logic [NCH*NWAY-1:0]  xfer_o,
  output logic [NCH*NWAY-1:0]  cell_o
);
  localparam int NT = NCH * NWAY;
  localparam int TW = $clog2(NT);

  typedef enum logic [1:0] {PH_IDLE, PH_SEL, PH_XFER, PH_CELL} ph_t;

  ph_t           ph  [NT];
  logic [DW-1:0] cnt [NT];
  logic [DW-1:0] d_sel, d_xfer, d_cell;
  logic [PW-1:0] rem;
  logic [DW-1:0] gap;
  logic [TW-1:0] nt;

  logic [NT-1:0] want, grant;
  logic          all_idle, nt_free, issue;

  assign nt_free = (ph[nt] == PH_IDLE) || (ph[nt] == PH_CELL && cnt[nt] == '0);
  assign issue   = busy && tick_us && (rem != '0) && (gap == '0) && nt_free;

  always_comb begin
    all_idle = 1'b1;
    for (int t = 0; t < NT; t++) begin
      want[t] = (ph[t] == PH_SEL) && (cnt[t] == '0);
      if (ph[t] != PH_IDLE) all_idle = 1'b0;
    end
    for (int t = 0; t < NT; t++) begin
      grant[t] = want[t];
      for (int u = 0; u < NT; u++) begin
        if (u != t && (u % NCH) == (t % NCH)) begin
          if (ph[u] == PH_XFER && cnt[u] != '0) grant[t] = 1'b0;
          if (u < t && want[u])                 grant[t] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      issue_stb <= 1'b0;
      issue_tgt <= '0;
      rem       <= '0;
      gap       <= '0;
      nt        <= '0;
      d_sel     <= '0;
      d_xfer    <= '0;
      d_cell    <= '0;
    end else begin
      done      <= 1'b0;
      issue_stb <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        rem    <= page_cnt;
        nt     <= '0;
        gap    <= '0;
        d_sel  <= op_rd ? rd_sel_dly  : wr_sel_dly;
        d_xfer <= op_rd ? rd_xfer_dly : wr_xfer_dly;
        d_cell <= op_rd ? rd_cell_dly : wr_cell_dly;
      end else if (busy && tick_us) begin
        if (issue) begin
          rem       <= rem - 1'b1;
          nt        <= (nt == TW'(NT - 1)) ? '0 : nt + 1'b1;
          gap       <= d_sel - 1'b1;
          issue_stb <= 1'b1;
          issue_tgt <= nt;
        end else if (rem != '0 && gap != '0) begin
          gap <= gap - 1'b1;
        end
        if (rem == '0 && all_idle) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        ph[t]  <= PH_IDLE;
        cnt[t] <= '0;
      end
    end else if (tick_us) begin
      for (int t = 0; t < NT; t++) begin
        if (issue && nt == TW'(t)) begin
          ph[t]  <= PH_SEL;
          cnt[t] <= d_sel - 1'b1;
        end else begin
          case (ph[t])
            PH_SEL: begin
              if (cnt[t] != '0) cnt[t] <= cnt[t] - 1'b1;
              else if (grant[t]) begin
                ph[t]  <= PH_XFER;
                cnt[t] <= d_xfer - 1'b1;
              end
            end
            PH_XFER: begin
              if (cnt[t] != '0) cnt[t] <= cnt[t] - 1'b1;
              else begin
                ph[t]  <= PH_CELL;
                cnt[t] <= d_cell - 1'b1;
              end
            end
            PH_CELL: begin
              if (cnt[t] != '0) cnt[t] <= cnt[t] - 1'b1;
              else ph[t] <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_out
    assign sel_o[t]  = (ph[t] == PH_SEL);
    assign xfer_o[t] = (ph[t] == PH_XFER);
    assign cell_o[t] = (ph[t] == PH_CELL);
  end
endmodule

// File: rtl/flash_page_dispatch_chk.sv
`timescale 1ns/1ps
module flash_page_dispatch_chk #(
  parameter int NCH  = 2,
  parameter int NWAY = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_us,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                issue_stb,
  input logic [NCH*NWAY-1:0] sel_o,
  input logic [NCH*NWAY-1:0] xfer_o,
  input logic [NCH*NWAY-1:0] cell_o
);
  localparam int NT = NCH * NWAY;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NWAY-1:0] chx;
    for (genvar w = 0; w < NWAY; w++) begin : g_w
      assign chx[w] = xfer_o[c + w * NCH];
    end
    a_r4_one_xfer_per_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chx) <= 1);
  end

  for (genvar t = 0; t < NT; t++) begin : g_tg
    a_r1_sel_then_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_o[t]) |-> xfer_o[t]);
    a_r1_xfer_then_cell: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_o[t]) |-> cell_o[t]);
  end

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_us |=> $stable({sel_o, xfer_o, cell_o}));

  a_r9_issue_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb |-> $past(tick_us && busy));

  a_r6_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sel_o == '0 && xfer_o == '0 && cell_o == '0));

  a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind flash_page_dispatch flash_page_dispatch_chk #(.NCH(NCH), .NWAY(NWAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start), .busy(busy),
  .done(done), .issue_stb(issue_stb), .sel_o(sel_o), .xfer_o(xfer_o), .cell_o(cell_o)
);

// File: tb/flash_page_dispatch_tb_top.sv
`timescale 1ns/1ps
module flash_page_dispatch_tb_top;
  localparam int NCH = 2, NWAY = 2, DW = 12, PW = 10;
  localparam int NT = NCH * NWAY, TW = $clog2(NT);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, start = 1'b0, op_rd = 1'b0;
  logic [PW-1:0] page_cnt = '0;
  logic [DW-1:0] wsel = 1, wxf = 1, wcl = 1, rsel = 1, rxf = 1, rcl = 1;
  logic busy, done, issue_stb;
  logic [TW-1:0] issue_tgt;
  logic [NT-1:0] sel_o, xfer_o, cell_o;

  flash_page_dispatch #(.NCH(NCH), .NWAY(NWAY), .DW(DW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .start(start), .op_rd(op_rd),
    .page_cnt(page_cnt), .wr_sel_dly(wsel), .wr_xfer_dly(wxf), .wr_cell_dly(wcl),
    .rd_sel_dly(rsel), .rd_xfer_dly(rxf), .rd_cell_dly(rcl),
    .busy(busy), .done(done), .issue_stb(issue_stb), .issue_tgt(issue_tgt),
    .sel_o(sel_o), .xfer_o(xfer_o), .cell_o(cell_o));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit sparse = 1'b0, mon_en = 1'b0, tick_q = 1'b1;
  int iss_cnt, seq_err, ovl, hold_err;
  int sel_n [NT], xf_n [NT], cl_n [NT];
  logic [3*NT-1:0] prev_ph = '0;

  always @(negedge clk) tick <= sparse ? ~tick : 1'b1;
  always @(posedge clk) tick_q = tick;

  always @(negedge clk) begin
    if (mon_en) begin
      if (issue_stb) begin
        if (int'(issue_tgt) != iss_cnt % NT) seq_err++;
        iss_cnt++;
      end
      for (int c = 0; c < NCH; c++) begin
        int k;
        k = 0;
        for (int w = 0; w < NWAY; w++) k += int'(xfer_o[c + w * NCH]);
        if (k > 1) ovl++;
      end
      for (int t = 0; t < NT; t++) begin
        sel_n[t] += int'(sel_o[t]);
        xf_n[t]  += int'(xfer_o[t]);
        cl_n[t]  += int'(cell_o[t]);
      end
      if (!tick_q && {sel_o, xfer_o, cell_o} != prev_ph) hold_err++;
    end
    prev_ph = {sel_o, xfer_o, cell_o};
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat_exp(input int n, input int s, input int x, input int c);
    int p, cyc, tw;
    if (n == 0) return 1;
    p = s + x + c;
    cyc = (n + NT - 1) / NT;
    tw = (p > NT * s) ? p - NT * s : 0;
    return s * (n - 1) + tw * (cyc - 1) + p + 2;
  endfunction

  task automatic run_op(input int op, input int n, input int s, input int x, input int c,
                        input int ig, output int lat);
    bit got;
    got = 1'b0;
    lat = 0;
    @(negedge clk);
    op_rd = op[0];
    page_cnt = PW'(n);
    if (op != 0) begin rsel = DW'(s); rxf = DW'(x); rcl = DW'(c); wsel = 7; wxf = 7; wcl = 7; end
    else         begin wsel = DW'(s); wxf = DW'(x); wcl = DW'(c); rsel = 9; rxf = 9; rcl = 9; end
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    iss_cnt = 0; seq_err = 0; ovl = 0; hold_err = 0;
    for (int t = 0; t < NT; t++) begin sel_n[t] = 0; xf_n[t] = 0; cl_n[t] = 0; end
    mon_en = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      if (tick_q) lat++;
      #1 start = 1'b0;
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
      if (ig != 0 && lat == ig) begin start = 1'b1; page_cnt = 1; end
    end
    mon_en = 1'b0;
    if (!got) begin
      fails++;
      $display("FAIL R6 run without done: actual 0 expected 1");
    end
    repeat (2) @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 4, 2, 3, 5},
    '{0, 5, 2, 3, 5},
    '{0, 9, 1, 2, 6},
    '{1, 6, 1, 1, 2},
    '{0, 2, 3, 1, 1},
    '{1, 8, 2, 4, 3}
  };

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat, k0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !issue_stb, "R11", "busy/done/issue after reset", int'({busy, done, issue_stb}), 0);
    chk({sel_o, xfer_o, cell_o} == '0, "R11", "phases after reset", int'({sel_o, xfer_o, cell_o}), 0);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, lat);
      k0 = (VEC[v][1] + NT - 1) / NT;
      chk(lat == lat_exp(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]),
          (VEC[v][1] % NT != 0) ? "R3 R5 R6 R8" : "R3 R6 R8", "latency in ticks",
          lat, lat_exp(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]));
      chk(iss_cnt == VEC[v][1], "R2", "issue strobes", iss_cnt, VEC[v][1]);
      chk(seq_err == 0, "R2", "round-robin target errors", seq_err, 0);
      chk(ovl == 0, "R4", "same-channel transfer overlaps", ovl, 0);
      chk(sel_n[0] == k0 * VEC[v][2], "R1", "target 0 select clocks", sel_n[0], k0 * VEC[v][2]);
      chk(xf_n[0] == k0 * VEC[v][3], "R1", "target 0 transfer clocks", xf_n[0], k0 * VEC[v][3]);
      chk(cl_n[0] == k0 * VEC[v][4], "R1", "target 0 cell clocks", cl_n[0], k0 * VEC[v][4]);
    end

    // R4: transfer longer than NCH select delays forces target 2 to wait on channel 0
    run_op(0, 3, 1, 4, 1, 0, lat);
    chk(lat == 12, "R4", "latency with channel wait", lat, 12);
    chk(ovl == 0, "R4", "overlaps with channel wait", ovl, 0);
    chk(sel_n[2] == 3, "R4", "target 2 held in select", sel_n[2], 3);
    chk(xf_n[2] == 4, "R4", "target 2 transfer clocks", xf_n[2], 4);

    // R10: empty request
    run_op(0, 0, 2, 2, 2, 0, lat);
    chk(lat == 1, "R10", "zero-page latency", lat, 1);
    chk(iss_cnt == 0, "R10", "zero-page issues", iss_cnt, 0);

    // R7: start while busy must not disturb the request
    run_op(0, 4, 2, 3, 5, 5, lat);
    chk(lat == lat_exp(4, 2, 3, 5), "R7", "latency with ignored start", lat, lat_exp(4, 2, 3, 5));
    chk(iss_cnt == 4, "R7", "issues with ignored start", iss_cnt, 4);
    chk(!busy, "R7", "no second request started", int'(busy), 0);

    // R9: tick on alternate clocks
    sparse = 1'b1;
    run_op(0, 5, 2, 3, 5, 0, lat);
    sparse = 1'b0;
    chk(lat == lat_exp(5, 2, 3, 5), "R9", "latency in ticks, sparse tick", lat, lat_exp(5, 2, 3, 5));
    chk(hold_err == 0, "R9", "phase changes without tick", hold_err, 0);
    chk(iss_cnt == 5, "R9", "issues, sparse tick", iss_cnt, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule